// File: doc/BRIEF.md
# RAM Chip-Enable Gating Controller

This block sits on the active-low chip-enable line of a battery-backed RAM. While the system is out of reset, the incoming strobe goes straight through to the RAM with no register in the path. When the supervisor raises its internal reset state, the block closes the path and holds the RAM-side strobe high (inactive). With the path closed, a failing supply cannot cause a stray write to corrupt the retained data.

Closing is not always instant. If no access is in flight when reset arrives (strobe high), the gate closes at once. If an access is in flight (strobe low), the gate stays open so that the write can complete. It then closes when the strobe returns high or when a fixed window of microsecond ticks has elapsed, whichever happens first. The window length is a parameter, and the tick counter starts from zero on every reset entry.

After reset is released, the gate opens again only in a cycle where the incoming strobe is high. A low pulse that is already under way is therefore never passed on half-finished. A status output reports whether the gate is currently closed.

Top module: `cegate_top`

## Requirements
- R1: While the gate is open, `ceOutN` equals `ceInN` combinationally, in the same cycle, for every level and transition.
- R2: While the gate is closed (`gateClosed`=1), `ceOutN` is driven 1 whatever `ceInN` is.
- R3: If `resetActive` is 1 in a clock cycle where the gate is open, not draining, and `ceInN`=1, then `gateClosed` is 1 after that clock edge.
- R4: If reset is entered with `ceInN`=0, the gate stays open and passes the low level. In the cycle where `ceInN` returns to 1, `ceOutN` follows it to 1, and `gateClosed` is 1 after the next edge.
- R5: If reset is entered with `ceInN`=0 and `ceInN` stays low, the gate stays open through the first TIMEOUT_US-1 `usTick` pulses. It closes on the edge that samples the TIMEOUT_US-th pulse (default 10), and `ceOutN` is 1 from then on.
- R6: While `resetActive` stays 1, a closed gate stays closed; `ceInN` toggles and ticks have no effect on `ceOutN` or `gateClosed`.
- R7: A closed gate opens on the first edge at which `resetActive`=0 and `ceInN`=1. While `ceInN`=0 it stays closed even with reset released.
- R8: The tick count starts from zero at each reset entry, so every drain window lasts the full TIMEOUT_US ticks whatever ticks an earlier drain counted.
- R9: While `rstN` is low, and after it is released, the gate is closed (`gateClosed`=1, `ceOutN`=1).
- R10: If `resetActive` returns to 0 during a drain window, the gate goes back to open without closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| usTick | input | 1 | One-cycle pulse once per microsecond |
| resetActive | input | 1 | Supervisor reset state, 1 = reset asserted |
| ceInN | input | 1 | Chip-enable from the processor, active low |
| ceOutN | output | 1 | Gated chip-enable to the RAM, active low |
| gateClosed | output | 1 | 1 while the path is blocked |

## Verification
Reset entry is tried with three strobe patterns. Entry with the strobe high separates an immediate close from a drain. Entry with a short low pulse shows that the rising strobe, not the timer, ends the drain. Entry with a low held past nine ticks pins the exact tick on which the timeout closes the gate. Further cases check that a closed gate ignores strobe toggles and ticks during reset, that the gate refuses to reopen while the strobe is low after release, and that a drain aborted by release leaves no stale tick count for the next one.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

  typedef enum logic [1:0] {
    GATE_OPEN   = 2'd0,
    GATE_DRAIN  = 2'd1,
    GATE_CLOSED = 2'd2
  } gate_state_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearCount;
    logic countEn;
    logic passEn;
  } gate_strobe_t;

endpackage

// File: rtl/cegate_datapath.sv
module cegate_datapath
  import cegate_pkg::*;
#(
  parameter int TIMEOUT_US = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         usTick,
  input  logic         ceInN,
  input  gate_strobe_t strobe,
  output logic         timeoutHit,
  output logic         ceOutN
);

  localparam int CNT_W = $clog2(TIMEOUT_US + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_US - 1);

  logic [CNT_W-1:0] tickCount;

  assign timeoutHit = strobe.countEn && usTick && (tickCount == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (strobe.clearCount) begin
      tickCount <= '0;
    end else if (strobe.countEn && usTick && !timeoutHit) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  // pass-through is combinational; closed forces inactive high
  assign ceOutN = strobe.passEn ? ceInN : 1'b1;

  // R5: the window counter never runs past its last value
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= LAST_CNT);

  // R8: outside a drain the count is back at zero on the next cycle
  p_count_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> (tickCount == '0));

endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl
  import cegate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         resetActive,
  input  logic         ceInN,
  input  logic         timeoutHit,
  output gate_strobe_t strobe,
  output logic         gateClosed
);

  gate_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      GATE_OPEN: begin
        if (resetActive) stateNext = ceInN ? GATE_CLOSED : GATE_DRAIN;
      end
      GATE_DRAIN: begin
        if (!resetActive)             stateNext = GATE_OPEN;
        else if (ceInN || timeoutHit) stateNext = GATE_CLOSED;
      end
      GATE_CLOSED: begin
        if (!resetActive && ceInN) stateNext = GATE_OPEN;
      end
      default: stateNext = GATE_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GATE_CLOSED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.passEn     = (state != GATE_CLOSED);
    strobe.countEn    = (state == GATE_DRAIN);
    strobe.clearCount = (state != GATE_DRAIN);
  end

  assign gateClosed = (state == GATE_CLOSED);

  // R3: idle strobe at reset entry closes the gate on the next edge
  p_idle_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_OPEN && resetActive && ceInN) |=> gateClosed);

  // R6: closed stays closed while reset holds
  p_hold_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gateClosed && resetActive) |=> gateClosed);

  // R7: opening only happens from a released reset with strobe high
  p_reopen_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateClosed) |-> $past(!resetActive && ceInN));

endmodule

// File: rtl/cegate_top.sv
module cegate_top
  import cegate_pkg::*;
#(
  parameter int TIMEOUT_US = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic resetActive,
  input  logic ceInN,
  output logic ceOutN,
  output logic gateClosed
);

  gate_strobe_t strobe;
  logic         timeoutHit;

  cegate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resetActive(resetActive),
    .ceInN      (ceInN),
    .timeoutHit (timeoutHit),
    .strobe     (strobe),
    .gateClosed (gateClosed)
  );

  cegate_datapath #(.TIMEOUT_US(TIMEOUT_US)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .usTick    (usTick),
    .ceInN     (ceInN),
    .strobe    (strobe),
    .timeoutHit(timeoutHit),
    .ceOutN    (ceOutN)
  );

  // R2: a closed gate always presents an inactive strobe
  p_closed_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    gateClosed |-> ceOutN);

  // R1: out of reset with the gate open, the strobe passes unchanged
  p_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!resetActive && !gateClosed) |-> (ceOutN == ceInN));

endmodule

// File: tb/tb_cegate_top.sv
module tb_cegate_top;

  localparam int TIMEOUT_US = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic resetActive = 1'b0;
  logic ceInN = 1'b0;
  logic ceOutN, gateClosed;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cegate_top #(.TIMEOUT_US(TIMEOUT_US)) dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .resetActive(resetActive),
    .ceInN(ceInN), .ceOutN(ceOutN), .gateClosed(gateClosed)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    usTick = 1'b1;
    step();
    usTick = 1'b0;
    step();
  endtask

  // release supervisor reset and open the gate with the strobe idle
  task automatic reopen();
    resetActive = 1'b0;
    ceInN = 1'b1;
    step();
    check("R7", "gateClosed after open", gateClosed, 1'b0);
  endtask

  task automatic t_reset_state();
    ceInN = 1'b0;
    resetActive = 1'b0;
    repeat (2) step();
    check("R9", "gateClosed in rstN", gateClosed, 1'b1);
    check("R9", "ceOutN in rstN", ceOutN, 1'b1);
    rstN = 1'b1;
    step();
    step();
    check("R7", "stay closed with ceIn low", gateClosed, 1'b1);
    check("R2", "ceOutN closed", ceOutN, 1'b1);
    ceInN = 1'b1;
    step();
    check("R7", "opens with ceIn high", gateClosed, 1'b0);
  endtask

  task automatic t_pass();
    ceInN = 1'b0; #1;
    check("R1", "follow low", ceOutN, 1'b0);
    step();
    ceInN = 1'b1; #1;
    check("R1", "follow high", ceOutN, 1'b1);
    step();
    ceInN = 1'b0; #1;
    check("R1", "follow low again", ceOutN, 1'b0);
    tick();
    check("R1", "still low after tick", ceOutN, 1'b0);
    ceInN = 1'b1; #1;
    check("R1", "follow rise", ceOutN, 1'b1);
    step();
  endtask

  task automatic t_entry_high();
    ceInN = 1'b1;
    resetActive = 1'b1;
    step();
    check("R3", "closed after idle entry", gateClosed, 1'b1);
    ceInN = 1'b0; #1;
    check("R6", "ceOutN ignores low in reset", ceOutN, 1'b1);
    for (int i = 0; i < TIMEOUT_US + 2; i++) tick();
    check("R6", "still closed after ticks", gateClosed, 1'b1);
    check("R2", "ceOutN high while closed", ceOutN, 1'b1);
    resetActive = 1'b0;
    step();
    check("R7", "closed while ceIn low after release", gateClosed, 1'b1);
    check("R2", "ceOutN high after release", ceOutN, 1'b1);
    reopen();
  endtask

  task automatic t_entry_short_low();
    ceInN = 1'b0;
    resetActive = 1'b1;
    step();
    check("R4", "open during drain", gateClosed, 1'b0);
    check("R4", "low passed during drain", ceOutN, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    ceInN = 1'b1; #1;
    check("R4", "rise passed", ceOutN, 1'b1);
    step();
    check("R4", "closed after rise", gateClosed, 1'b1);
    ceInN = 1'b0;
    step();
    check("R6", "later low blocked", ceOutN, 1'b1);
    reopen();
  endtask

  task automatic t_entry_timeout();
    ceInN = 1'b0;
    resetActive = 1'b1;
    step();
    for (int i = 0; i < TIMEOUT_US - 1; i++) tick();
    check("R5", "open before last tick", gateClosed, 1'b0);
    check("R5", "low held before last tick", ceOutN, 1'b0);
    usTick = 1'b1;
    step();
    usTick = 1'b0;
    check("R5", "closed at last tick", gateClosed, 1'b1);
    check("R5", "ceOutN forced high", ceOutN, 1'b1);
    reopen();
  endtask

  task automatic t_counter_clear();
    ceInN = 1'b0;
    resetActive = 1'b1;
    step();
    for (int i = 0; i < 6; i++) tick();
    resetActive = 1'b0;
    step();
    check("R10", "open after release in drain", gateClosed, 1'b0);
    check("R10", "low still passed", ceOutN, 1'b0);
    resetActive = 1'b1;
    step();
    for (int i = 0; i < TIMEOUT_US - 1; i++) tick();
    check("R8", "full window after re-entry", gateClosed, 1'b0);
    tick();
    check("R8", "closed after full window", gateClosed, 1'b1);
    reopen();
  endtask

  initial begin
    t_reset_state();
    t_pass();
    t_entry_high();
    t_pass();
    t_entry_short_low();
    t_entry_timeout();
    t_counter_clear();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule